// File: doc/BRIEF.md
# Control-Pin Mode Decoder and Power Sequencer

This block turns two synchronized control pins into the per-output enable requests, a bypass select for the reference clock path and a device-wide oscillator run signal. Four configuration bits decide what each pin means. Pin 0 can be an output enable for the reference output, a frequency select between the undivided and the prescaled master clock, a power-down for the reference output alone, or a device power-down. Pin 1 is either the output enable for the main output or a device power-down.

A power-down request is the OR of each pin gated by its power-down bit. The request takes effect only after it has been held for a programmable number of slow timer ticks. Once a request is accepted, both outputs are gated off first and the oscillator is stopped a fixed number of cycles later. Register programming is locked out for the whole power-down period. After reset or wake-up, the outputs stay gated until a stabilization count of master clock cycles has elapsed. A new request that appears during that count starts the count over.

Top module: `cpm_pwr_seq`

## Requirements
- R1: With cfg_pdn0=1, pin 0 never gates the reference output: ref_oe is 1 whenever the block is running, and ref_bypass equals the inverse of cfg_sel0 (1 = undivided clock).
- R2: With cfg_pdn0=0 and cfg_en0=1, ctl0=0 enables the reference output and ctl0=1 disables it. ref_bypass equals the inverse of cfg_sel0.
- R3: With cfg_en0=cfg_pdn0=0 and cfg_sel0=1, the reference output is always enabled. ctl0=0 gives ref_bypass=1 (undivided) and ctl0=1 gives ref_bypass=0 (prescaled).
- R4: With cfg_en0=cfg_sel0=cfg_pdn0=0, ctl0=1 shuts off only the reference output while osc_run stays 1. ctl0=0 enables it with ref_bypass=1.
- R5: With cfg_pdn1=0, ctl1=0 enables the main output and ctl1=1 disables it. With cfg_pdn1=1, main_oe is 1 whenever the block is running.
- R6: The shutdown request is (cfg_pdn0 AND ctl0) OR (cfg_pdn1 AND ctl1). It is accepted only after it has stayed high across PERSIST_TICKS tick pulses. A request that drops before that has no effect, and its partial count is discarded.
- R7: On acceptance, ref_oe and main_oe go to 0 at the next clock edge. osc_run stays 1 for DRAIN_CYC cycles and then goes to 0.
- R8: After reset, and after a wake-up caused by the request dropping while stopped, both enables stay 0 for exactly STAB_CYC clock cycles and rise on the STAB_CYC-th edge.
- R9: prog_lock is 1 from the start of the drain until the wake-up edge, and 0 otherwise.
- R10: A shutdown request that is raised during the stabilization count restarts that count. A full STAB_CYC cycles is then counted from the edge after the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse from the slow timer |
| ctl0 | input | 1 | Control pin 0, already synchronized |
| ctl1 | input | 1 | Control pin 1, already synchronized |
| cfg_en0 | input | 1 | Pin 0 output-enable role bit (reset default 1 in register storage) |
| cfg_sel0 | input | 1 | Reference clock select / pin 0 select-role bit (default 1) |
| cfg_pdn0 | input | 1 | Pin 0 power-down role bit (default 0) |
| cfg_pdn1 | input | 1 | Pin 1 power-down role bit (default 0) |
| ref_oe | output | 1 | Enable request for the reference output |
| main_oe | output | 1 | Enable request for the main output |
| ref_bypass | output | 1 | 1 selects the undivided clock for the reference output |
| osc_run | output | 1 | Oscillator run request |
| prog_lock | output | 1 | Register programming locked out |

## Verification
The decode is swept over all sixteen combinations of the three pin-0 role bits and ctl0, and over all four combinations of the pin-1 role bit and ctl1. Expected enable and bypass values are derived arithmetically, which separates the four roles of pin 0 from each other. Power sequencing is first driven with a request held one tick short, dropped and raised again; this separates a persistence counter that clears from one that accumulates. Full-length requests from each pin then check the drain order, the stop, the lockout and the exact length of the warm-up. A request raised in the middle of the warm-up checks that the count restarts and does not resume.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic [1:0] {
    PS_WARM  = 2'd0,
    PS_RUN   = 2'd1,
    PS_DRAIN = 2'd2,
    PS_OFF   = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/cpm_pin_decode.sv
module cpm_pin_decode (
  input  logic ctl0,
  input  logic ctl1,
  input  logic en0,
  input  logic sel0,
  input  logic pdn0,
  input  logic pdn1,
  output logic ref_on,
  output logic main_on,
  output logic bypass,
  output logic pd_raw
);
  // pin 0 role: power-down > output enable > frequency select > ref-only shutdown
  always_comb begin
    if (pdn0) begin
      ref_on = 1'b1;
      bypass = ~sel0;
    end else if (en0) begin
      ref_on = ~ctl0;
      bypass = ~sel0;
    end else if (sel0) begin
      ref_on = 1'b1;
      bypass = ~ctl0;
    end else begin
      ref_on = ~ctl0;
      bypass = 1'b1;
    end
  end

  assign main_on = pdn1 | ~ctl1;
  assign pd_raw  = (pdn0 & ctl0) | (pdn1 & ctl1);
endmodule

// File: rtl/cpm_req_filter.sv
module cpm_req_filter #(
  parameter int PERSIST_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic accepted
);
  localparam int PW = $clog2(PERSIST_TICKS + 1);
  localparam logic [PW-1:0] P_FULL = PW'(PERSIST_TICKS);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pcnt <= '0;
    else if (!req)                  pcnt <= '0;
    else if (tick && pcnt != P_FULL) pcnt <= pcnt + 1'b1;
  end

  assign accepted = req && (pcnt == P_FULL);
endmodule

// File: rtl/cpm_pwr_fsm.sv
module cpm_pwr_fsm
  import cpm_pkg::*;
#(
  parameter int STAB_CYC  = 8000,
  parameter int DRAIN_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_raw,
  input  logic       pd_ok,
  output pwr_state_t state
);
  localparam int SW = $clog2(STAB_CYC);
  localparam int DW = $clog2(DRAIN_CYC + 1);
  localparam logic [SW-1:0] STAB_LAST  = SW'(STAB_CYC - 1);
  localparam logic [DW-1:0] DRAIN_LAST = DW'(DRAIN_CYC - 1);

  logic [SW-1:0] scnt;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_WARM;
      scnt  <= '0;
      dcnt  <= '0;
    end else begin
      case (state)
        PS_WARM: begin
          if (pd_raw) begin
            scnt <= '0;
            if (pd_ok) begin
              state <= PS_DRAIN;
              dcnt  <= '0;
            end
          end else if (scnt == STAB_LAST) begin
            state <= PS_RUN;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        PS_RUN: begin
          if (pd_ok) begin
            state <= PS_DRAIN;
            dcnt  <= '0;
          end
        end
        PS_DRAIN: begin
          if (dcnt == DRAIN_LAST) state <= PS_OFF;
          else                    dcnt  <= dcnt + 1'b1;
        end
        default: begin
          if (!pd_raw) begin
            state <= PS_WARM;
            scnt  <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cpm_pwr_seq.sv
module cpm_pwr_seq
  import cpm_pkg::*;
#(
  parameter int STAB_CYC      = 8000,
  parameter int PERSIST_TICKS = 3,
  parameter int DRAIN_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ctl0,
  input  logic ctl1,
  input  logic cfg_en0,
  input  logic cfg_sel0,
  input  logic cfg_pdn0,
  input  logic cfg_pdn1,
  output logic ref_oe,
  output logic main_oe,
  output logic ref_bypass,
  output logic osc_run,
  output logic prog_lock
);
  logic ref_on, main_on, pd_raw, pd_ok;
  pwr_state_t state;

  cpm_pin_decode u_dec (
    .ctl0(ctl0), .ctl1(ctl1),
    .en0(cfg_en0), .sel0(cfg_sel0), .pdn0(cfg_pdn0), .pdn1(cfg_pdn1),
    .ref_on(ref_on), .main_on(main_on), .bypass(ref_bypass), .pd_raw(pd_raw)
  );

  cpm_req_filter #(.PERSIST_TICKS(PERSIST_TICKS)) u_flt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(pd_raw), .accepted(pd_ok)
  );

  cpm_pwr_fsm #(.STAB_CYC(STAB_CYC), .DRAIN_CYC(DRAIN_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_raw(pd_raw), .pd_ok(pd_ok), .state(state)
  );

  assign ref_oe    = (state == PS_RUN) && ref_on;
  assign main_oe   = (state == PS_RUN) && main_on;
  assign osc_run   = (state != PS_OFF);
  assign prog_lock = (state == PS_DRAIN) || (state == PS_OFF);
endmodule

// File: rtl/cpm_pwr_seq_chk.sv
module cpm_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl0,
  input logic ctl1,
  input logic cfg_en0,
  input logic cfg_pdn0,
  input logic cfg_pdn1,
  input logic ref_oe,
  input logic main_oe,
  input logic osc_run,
  input logic prog_lock
);
  p_dark_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> (!ref_oe && !main_oe));

  p_gate_before_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_run) |-> $past(!ref_oe && !main_oe));

  p_lock_while_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> prog_lock);

  p_wake_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_run) |-> (!ref_oe && !main_oe && !prog_lock));

  p_main_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    main_oe |-> (cfg_pdn1 || !ctl1));

  p_ref_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_oe && !cfg_pdn0 && cfg_en0) |-> !ctl0);
endmodule

bind cpm_pwr_seq cpm_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl0(ctl0), .ctl1(ctl1),
  .cfg_en0(cfg_en0), .cfg_pdn0(cfg_pdn0), .cfg_pdn1(cfg_pdn1),
  .ref_oe(ref_oe), .main_oe(main_oe), .osc_run(osc_run), .prog_lock(prog_lock)
);

// File: tb/tb_cpm_pwr_seq.sv
module tb_cpm_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STAB       = 20;
  localparam int PERSIST    = 3;
  localparam int DRAIN      = 2;

  logic clk = 0, rst_n = 0, tick = 0, ctl0 = 0, ctl1 = 0;
  logic cfg_en0 = 1, cfg_sel0 = 1, cfg_pdn0 = 0, cfg_pdn1 = 0;
  logic ref_oe, main_oe, ref_bypass, osc_run, prog_lock;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpm_pwr_seq #(.STAB_CYC(STAB), .PERSIST_TICKS(PERSIST), .DRAIN_CYC(DRAIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl0(ctl0), .ctl1(ctl1),
    .cfg_en0(cfg_en0), .cfg_sel0(cfg_sel0), .cfg_pdn0(cfg_pdn0), .cfg_pdn1(cfg_pdn1),
    .ref_oe(ref_oe), .main_oe(main_oe), .ref_bypass(ref_bypass),
    .osc_run(osc_run), .prog_lock(prog_lock)
  );

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  // Expects both enables (configured on) to stay low for STAB-1 edges and rise on edge STAB.
  task automatic wait_warm(string req);
    for (int k = 1; k <= STAB; k++) begin
      @(posedge clk); @(negedge clk);
      check(req, "warm main_oe", main_oe, k == STAB);
      check(req, "warm ref_oe", ref_oe, k == STAB);
    end
  endtask

  function automatic logic exp_ref_on(logic en, logic sel, logic pdn, logic c);
    if (pdn) return 1'b1;
    if (en)  return ~c;
    if (sel) return 1'b1;
    return ~c;
  endfunction

  function automatic logic exp_byp(logic en, logic sel, logic pdn, logic c);
    if (pdn || en) return ~sel;
    if (sel)       return ~c;
    return 1'b1;
  endfunction

  function automatic string mode_tag(logic en, logic sel, logic pdn);
    if (pdn) return "R1";
    if (en)  return "R2";
    if (sel) return "R3";
    return "R4";
  endfunction

  initial begin
    #1;
    check("R8", "reset ref_oe", ref_oe, 0);
    check("R8", "reset main_oe", main_oe, 0);
    check("R9", "reset lock", prog_lock, 0);
    check("R7", "reset osc_run", osc_run, 1);
    @(negedge clk); @(negedge clk) rst_n = 1;
    wait_warm("R8");

    // pin 0 role sweep (no ticks, so no request is accepted)
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {cfg_en0, cfg_sel0, cfg_pdn0, ctl0} = 4'(v);
      #1;
      check(mode_tag(cfg_en0, cfg_sel0, cfg_pdn0), "ref_oe", ref_oe,
            exp_ref_on(cfg_en0, cfg_sel0, cfg_pdn0, ctl0));
      if (exp_ref_on(cfg_en0, cfg_sel0, cfg_pdn0, ctl0))
        check(mode_tag(cfg_en0, cfg_sel0, cfg_pdn0), "ref_bypass", ref_bypass,
              exp_byp(cfg_en0, cfg_sel0, cfg_pdn0, ctl0));
      check("R4", "main_oe unaffected", main_oe, 1);
      check("R6", "osc_run", osc_run, 1);
    end
    // pin 1 role sweep
    @(negedge clk) {cfg_en0, cfg_sel0, cfg_pdn0, ctl0} = 4'b1100;
    for (int v = 0; v < 4; v++) begin
      @(negedge clk) {cfg_pdn1, ctl1} = 2'(v);
      #1;
      check("R5", "main_oe", main_oe, cfg_pdn1 | ~ctl1);
      check("R5", "ref_oe unaffected", ref_oe, 1);
    end

    // R4: ref-only shutdown persists across ticks without stopping oscillator
    @(negedge clk) begin {cfg_en0, cfg_sel0, cfg_pdn0, ctl0} = 4'b0001; {cfg_pdn1, ctl1} = 2'b00; end
    for (int k = 0; k < PERSIST + 2; k++) pulse_tick();
    #1;
    check("R4", "ref-only off", ref_oe, 0);
    check("R4", "osc kept running", osc_run, 1);
    check("R4", "main still on", main_oe, 1);

    // R6: short request discarded, then restarted count
    @(negedge clk) begin {cfg_en0, cfg_sel0, cfg_pdn0, ctl0} = 4'b1100; {cfg_pdn1, ctl1} = 2'b11; end
    for (int k = 0; k < PERSIST - 1; k++) pulse_tick();
    @(negedge clk) ctl1 = 0;
    @(negedge clk) ctl1 = 1;
    for (int k = 0; k < PERSIST - 1; k++) pulse_tick();
    repeat (3) @(negedge clk);
    check("R6", "short request ignored osc", osc_run, 1);
    check("R6", "short request ignored main", main_oe, 1);
    check("R9", "no lock yet", prog_lock, 0);
    pulse_tick();  // PERSIST-th tick captured; accepted from here
    check("R6", "still on before drain", main_oe, 1);
    @(posedge clk); @(negedge clk);
    check("R7", "main gated at drain", main_oe, 0);
    check("R7", "ref gated at drain", ref_oe, 0);
    check("R7", "osc still runs", osc_run, 1);
    check("R9", "lock at drain", prog_lock, 1);
    for (int k = 2; k <= DRAIN; k++) begin
      @(posedge clk); @(negedge clk);
      check("R7", "osc during drain", osc_run, 1);
    end
    @(posedge clk); @(negedge clk);
    check("R7", "osc stopped", osc_run, 0);
    check("R9", "lock while stopped", prog_lock, 1);
    repeat (5) @(negedge clk);
    check("R7", "still stopped", osc_run, 0);
    ctl1 = 0;
    @(posedge clk); @(negedge clk);
    check("R8", "woke osc", osc_run, 1);
    check("R9", "lock released", prog_lock, 0);
    check("R8", "woke gated", main_oe, 0);
    wait_warm("R8");

    // R10: request during warm-up restarts the count; pin 0 as device power-down
    @(negedge clk) begin cfg_pdn0 = 1; ctl0 = 1; end
    pulse_tick(); pulse_tick(); pulse_tick();
    @(posedge clk); @(negedge clk);  // drain entered
    repeat (DRAIN) @(negedge clk);
    check("R6", "pin0 shutdown stops osc", osc_run, 0);
    ctl0 = 0;
    @(posedge clk); @(negedge clk);
    check("R8", "pin0 wake", osc_run, 1);
    repeat (10) @(negedge clk);
    ctl0 = 1;
    repeat (4) @(negedge clk);
    check("R10", "gated during request", ref_oe, 0);
    ctl0 = 0;
    wait_warm("R10");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule